// File: doc/BRIEF.md
# Longest-Prefix Set Matcher

This block resolves a single set of a set-associative route store. All ways of the set arrive at once. Each way carries a valid flag, a stored prefix tag, a binary prefix length and an 8-bit next-hop port number. A lookup tag taken from the destination address arrives with them.

For each way, the block expands the stored length into a mask of ones aligned to the most significant bit of the tag. It then compares the lookup tag with the stored tag, but only under that mask. Any number of ways may match. A bus with one line per possible length then selects the longest matching entry. The block returns a hit flag, the winning length and the winning payload.

The work is split into two register stages. The first stage builds the masks and does the compares. The second stage does the length arbitration, so the arbitration logic never sits in the same cycle as the compare. The RAM arrays, index formation and any iteration over prefix classes sit outside this block. The way count and the tag width are parameters. The defaults are 4 ways, a 24-bit tag and a 5-bit length field.

Top module: `lpm_set_match`

## Requirements
- R1: A valid way with stored length L matches when the L most significant bits of its stored tag (bit 23 is the MSB) equal those of the lookup tag; the tag bits below those L bits are ignored.
- R2: A way whose valid bit is 0 never matches, whatever its tag and length.
- R3: A valid way with stored length 0 matches every lookup tag.
- R4: When several ways match, the result carries the greatest stored length among them and that way's payload.
- R5: When matching ways tie on the greatest length, the lowest-numbered way wins (way 0 occupies the lowest slice of each packed way bus).
- R6: When no way matches, res_hit is 0 and res_len and res_hop are both 0.
- R7: A lookup sampled with look_vld high at one rising edge produces its result with res_vld high after the second rising edge. res_vld stays high for exactly one cycle per lookup.
- R8: While rst_n is low, res_vld, res_hit, res_len and res_hop are all 0.
- R9: While no lookup is completing, res_hit, res_len and res_hop keep the last result. Way contents presented with look_vld low do not change them.
- R10: A stored length above 24 behaves as length 24 and is reported as 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| look_vld | input | 1 | Lookup strobe |
| look_tag | input | TAG_W | Tag formed from the destination address |
| way_valid | input | WAYS | Valid flag per way |
| way_tag | input | WAYS*TAG_W | Stored tags, way 0 in the lowest slice |
| way_len | input | WAYS*LEN_W | Stored prefix lengths, binary |
| way_hop | input | WAYS*8 | Next-hop port numbers |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | A way matched |
| res_len | output | LEN_W | Length of the winning prefix |
| res_hop | output | 8 | Payload of the winning way |

## Verification
Some properties are checked on every cycle. The result strobe must advance through both stages in step with the lookup strobe. The reported length must equal the maximum matched length, found by a plain maximum reduction over the registered compare flags, which is separate from the per-length line bus. The grant must never select more than one way. A miss must drive zeros, and the outputs must stay still between results. Other behaviours come only from the bench's scenarios: masked bits being ignored, invalid ways being dropped, a length-0 entry catching everything, ties going to the lowest way, and length saturation. These depend on what the stored tags contain.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int HOP_W = 8;
    typedef logic [HOP_W-1:0] hop_t;
endpackage

// File: rtl/prefix_mask.sv
module prefix_mask #(
    parameter int TAG_W = 24,
    localparam int LEN_W = $clog2(TAG_W + 1)
) (
    input  logic [LEN_W-1:0] len,
    output logic [TAG_W-1:0] mask
);
    // bit i is covered when it lies within the top 'len' bits
    for (genvar i = 0; i < TAG_W; i++) begin : g_bit
        assign mask[i] = (len > LEN_W'(TAG_W - 1 - i));
    end
endmodule

// File: rtl/way_match.sv
module way_match #(
    parameter int TAG_W = 24,
    localparam int LEN_W = $clog2(TAG_W + 1)
) (
    input  logic             valid,
    input  logic [TAG_W-1:0] tag,
    input  logic [LEN_W-1:0] len,
    input  logic [TAG_W-1:0] look,
    output logic             hit,
    output logic [LEN_W-1:0] len_sat
);
    logic [TAG_W-1:0] mask;

    always_comb begin
        len_sat = (len > LEN_W'(TAG_W)) ? LEN_W'(TAG_W) : len;
    end

    prefix_mask #(.TAG_W(TAG_W)) u_mask (
        .len  (len_sat),
        .mask (mask)
    );

    always_comb begin
        hit = valid && (((tag ^ look) & mask) == '0);
    end
endmodule

// File: rtl/len_arbiter.sv
module len_arbiter
    import lpm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int LEN_W = $clog2(TAG_W + 1)
) (
    input  logic [WAYS-1:0]             match,
    input  logic [WAYS-1:0][LEN_W-1:0]  len,
    input  logic [WAYS-1:0][HOP_W-1:0]  hop,
    output logic                        hit,
    output logic [LEN_W-1:0]            win_len,
    output logic [HOP_W-1:0]            win_hop,
    output logic [WAYS-1:0]             grant
);
    logic [TAG_W:0] line;

    // every matching way raises the line of its own length
    always_comb begin
        line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) line[len[w]] = 1'b1;
        end
    end

    // highest raised line is the winning length
    always_comb begin
        win_len = '0;
        for (int l = 0; l <= TAG_W; l++) begin
            if (line[l]) win_len = LEN_W'(l);
        end
        hit = |line;
    end

    // ways on the winning line claim; the lowest-numbered claimant keeps the grant
    always_comb begin
        grant = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w] && len[w] == win_len) begin
                grant    = '0;
                grant[w] = 1'b1;
            end
        end
        win_hop = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (grant[w]) win_hop = hop[w];
        end
    end
endmodule

// File: rtl/lpm_set_match.sv
module lpm_set_match
    import lpm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int LEN_W = $clog2(TAG_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    look_vld,
    input  logic [TAG_W-1:0]        look_tag,
    input  logic [WAYS-1:0]         way_valid,
    input  logic [WAYS*TAG_W-1:0]   way_tag,
    input  logic [WAYS*LEN_W-1:0]   way_len,
    input  logic [WAYS*HOP_W-1:0]   way_hop,
    output logic                    res_vld,
    output logic                    res_hit,
    output logic [LEN_W-1:0]        res_len,
    output logic [HOP_W-1:0]        res_hop
);
    typedef struct packed {
        logic                        vld;
        logic [WAYS-1:0]             match;
        logic [WAYS-1:0][LEN_W-1:0]  len;
        logic [WAYS-1:0][HOP_W-1:0]  hop;
    } cmp_t;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [LEN_W-1:0]  len;
        logic [HOP_W-1:0]  hop;
    } res_t;

    cmp_t s1_d, s1_q;
    res_t s2_d, s2_q;

    logic [WAYS-1:0]            m_hit;
    logic [WAYS-1:0][LEN_W-1:0] m_len;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        way_match #(.TAG_W(TAG_W)) u_match (
            .valid   (way_valid[w]),
            .tag     (way_tag[w*TAG_W +: TAG_W]),
            .len     (way_len[w*LEN_W +: LEN_W]),
            .look    (look_tag),
            .hit     (m_hit[w]),
            .len_sat (m_len[w])
        );
    end

    logic             a_hit;
    logic [LEN_W-1:0] a_len;
    logic [HOP_W-1:0] a_hop;
    logic [WAYS-1:0]  a_grant;

    len_arbiter #(.WAYS(WAYS), .TAG_W(TAG_W)) u_arb (
        .match   (s1_q.match),
        .len     (s1_q.len),
        .hop     (s1_q.hop),
        .hit     (a_hit),
        .win_len (a_len),
        .win_hop (a_hop),
        .grant   (a_grant)
    );

    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = look_vld;
        if (look_vld) begin
            s1_d.match = m_hit;
            s1_d.len   = m_len;
            for (int w = 0; w < WAYS; w++) begin
                s1_d.hop[w] = way_hop[w*HOP_W +: HOP_W];
            end
        end
        s2_d     = s2_q;
        s2_d.vld = s1_q.vld;
        if (s1_q.vld) begin
            s2_d.hit = a_hit;
            s2_d.len = a_len;
            s2_d.hop = a_hop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign res_vld = s2_q.vld;
    assign res_hit = s2_q.hit;
    assign res_len = s2_q.len;
    assign res_hop = s2_q.hop;

    // independent maximum reduction over the registered compare flags
    logic             chk_any;
    logic [LEN_W-1:0] chk_max;
    always_comb begin
        chk_any = 1'b0;
        chk_max = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (s1_q.match[w]) begin
                chk_any = 1'b1;
                if (s1_q.len[w] > chk_max) chk_max = s1_q.len[w];
            end
        end
    end

    // R7
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        look_vld |=> s1_q.vld);

    // R7
    result_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.vld |=> res_vld);

    // R4
    longest_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.vld |=> (res_hit == $past(chk_any)) && (res_len == $past(chk_max)));

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_grant));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_len == '0 && res_hop == '0));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.vld |=> ($stable(res_hit) && $stable(res_len) && $stable(res_hop)));
endmodule

// File: tb/tb_lpm_set_match.sv
module tb_lpm_set_match;
    localparam int WAYS  = 4;
    localparam int TAG_W = 24;
    localparam int LEN_W = 5;
    localparam int HOP_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic look_vld = 1'b0;
    logic [TAG_W-1:0] look_tag = '0;
    logic [WAYS-1:0] way_valid = '0;
    logic [WAYS*TAG_W-1:0] way_tag = '0;
    logic [WAYS*LEN_W-1:0] way_len = '0;
    logic [WAYS*HOP_W-1:0] way_hop = '0;
    logic res_vld, res_hit;
    logic [LEN_W-1:0] res_len;
    logic [HOP_W-1:0] res_hop;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpm_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .look_vld(look_vld), .look_tag(look_tag),
        .way_valid(way_valid), .way_tag(way_tag), .way_len(way_len), .way_hop(way_hop),
        .res_vld(res_vld), .res_hit(res_hit), .res_len(res_len), .res_hop(res_hop)
    );

    function automatic logic [TAG_W-1:0] mk_mask(int len);
        int l = (len > TAG_W) ? TAG_W : len;
        logic [TAG_W-1:0] ones = '1;
        return (l == 0) ? '0 : (ones << (TAG_W - l));
    endfunction

    // expected {hit, len, hop}
    function automatic logic [1+LEN_W+HOP_W-1:0] ref_result();
        int best = -1;
        logic [HOP_W-1:0] h = '0;
        for (int w = 0; w < WAYS; w++) begin
            int l = int'(way_len[w*LEN_W +: LEN_W]);
            if (l > TAG_W) l = TAG_W;
            if (way_valid[w] &&
                (((way_tag[w*TAG_W +: TAG_W] ^ look_tag) & mk_mask(l)) == '0) &&
                l > best) begin
                best = l;
                h = way_hop[w*HOP_W +: HOP_W];
            end
        end
        if (best < 0) return '0;
        return {1'b1, LEN_W'(best), h};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_way(int w, bit v, logic [TAG_W-1:0] t, int l, logic [HOP_W-1:0] h);
        way_valid[w] = v;
        way_tag[w*TAG_W +: TAG_W] = t;
        way_len[w*LEN_W +: LEN_W] = LEN_W'(l);
        way_hop[w*HOP_W +: HOP_W] = h;
    endtask

    task automatic lookup(string req, logic [TAG_W-1:0] t);
        logic [1+LEN_W+HOP_W-1:0] exp;
        look_tag = t;
        exp = ref_result();
        look_vld = 1'b1;
        @(negedge clk);
        look_vld = 1'b0;
        check({req, " R7 no early strobe"}, 32'(res_vld), 32'd0);
        @(negedge clk);
        check({req, " R7 strobe"}, 32'(res_vld), 32'd1);
        check(req, 32'({res_hit, res_len, res_hop}), 32'(exp));
        @(negedge clk);
        check({req, " R7 single-cycle strobe"}, 32'(res_vld), 32'd0);
    endtask

    initial begin
        logic [HOP_W+LEN_W:0] snap;
        repeat (3) @(negedge clk);
        // R8
        check("R8 reset outputs", 32'({res_vld, res_hit, res_len, res_hop}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: all ways invalid
        for (int w = 0; w < WAYS; w++) set_way(w, 1'b0, '0, 0, 8'hAA);
        lookup("R6 all invalid miss", 24'h000000);

        // R3: length 0 catches everything
        set_way(2, 1'b1, 24'h123456, 0, 8'h33);
        lookup("R3 zero length match", 24'hFEDCBA);

        // R1: difference below mask ignored, inside mask detected
        set_way(2, 1'b0, '0, 0, 8'h0);
        set_way(1, 1'b1, 24'hC0A800, 16, 8'h11);
        lookup("R1 low bits ignored", 24'hC0A8FF);
        lookup("R1 masked bit differs", 24'hC0A900);
        set_way(1, 1'b1, 24'hC0A801, 24, 8'h12);
        lookup("R1 full length exact", 24'hC0A801);
        lookup("R1 full length lsb differs", 24'hC0A800);

        // R2: invalid way with a longer match is ignored
        set_way(0, 1'b0, 24'hABCDEF, 24, 8'h55);
        set_way(3, 1'b1, 24'hAB0000, 8, 8'h77);
        lookup("R2 invalid way dropped", 24'hABCDEF);

        // R4: longest of several matches wins
        for (int w = 0; w < WAYS; w++) set_way(w, 1'b1, 24'h0A0B0C, 4 + 5*w, 8'(8'h40 + w));
        lookup("R4 longest wins", 24'h0A0B0C);

        // R5: tie on greatest length goes to the lowest way
        set_way(0, 1'b1, 24'h0A0000, 8, 8'h01);
        set_way(1, 1'b1, 24'h0A0B00, 20, 8'h02);
        set_way(2, 1'b1, 24'h0A0000, 4, 8'h03);
        set_way(3, 1'b1, 24'h0A0B0F, 20, 8'h04);
        lookup("R5 tie lowest way", 24'h0A0B0C);
        check("R5 tie payload way1", 32'(res_hop), 32'h02);

        // R10: oversize length saturates
        for (int w = 0; w < WAYS; w++) set_way(w, 1'b0, '0, 0, 8'h0);
        set_way(3, 1'b1, 24'h777777, 31, 8'h9C);
        lookup("R10 saturated length", 24'h777777);
        check("R10 reported length", 32'(res_len), 32'd24);

        // R9: changes with look_vld low leave the result unchanged
        snap = {res_hit, res_len, res_hop};
        set_way(0, 1'b1, 24'h000000, 0, 8'hEE);
        look_tag = 24'h111111;
        repeat (3) @(negedge clk);
        check("R9 hold without lookup", 32'({res_hit, res_len, res_hop}), 32'(snap));

        // R4 R1 random: stored tags share a random prefix with the lookup tag
        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            logic [TAG_W-1:0] lt = TAG_W'($urandom);
            for (int w = 0; w < WAYS; w++) begin
                int l = int'($urandom_range(0, 24));
                int keep = int'($urandom_range(0, 24));
                logic [TAG_W-1:0] t = (lt & mk_mask(keep)) | (TAG_W'($urandom) & ~mk_mask(keep));
                set_way(w, ($urandom_range(0, 7) != 0), t, l, 8'($urandom));
            end
            lookup("R4 random", lt);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule